// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers interrupt requests from eight device lines and turns them into a single interrupt signal for a processor. A request is remembered on a rising edge of its line. A mask register holds requests back without losing them. Fixed priority then picks the lowest-numbered line that may be serviced. The processor answers with two acknowledge pulses. The first pulse moves the chosen line from pending to in-service. The second pulse makes the block place an 8-bit vector, equal to a base of 32 plus the line number, on a data output for one clock.

A line stays in service until software writes an end-of-service command. That command can clear the highest-priority in-service line, or a line it names. Lines of equal or lower priority than the most urgent in-service line are held back until then. A line of higher priority can still interrupt, so handlers nest.

All outputs are registered, and the reset is synchronous and active high. Both the request edges and the acknowledge pulses are detected inside the block, so an acknowledge held high for several clocks counts as one pulse.

Top module: `pic_core`

## Requirements
- R1: After reset no request is pending and no line is in service. Every mask bit is set, so a rising request line cannot raise `int_out`. `int_out` and `vec_oe` are low and `vec_out` is zero.
- R2: A rising edge on `irq_in[i]` records a pending request for line i. If line i is unmasked and nothing is in service, `int_out` is high after the next clock edge.
- R3: `int_out` is high exactly when some unmasked pending line has a strictly lower index than every in-service line. Line 0 has the highest priority.
- R4: On the first acknowledge pulse, the eligible pending line with the lowest index leaves the pending set and enters service. `int_out` falls if no other line is eligible.
- R5: On the second acknowledge pulse, `vec_out` carries 32 plus the selected line number, with `vec_oe` high. This lasts for exactly the one clock after the edge that samples the pulse.
- R6: Apart from that one clock, `vec_oe` is low and `vec_out` is zero.
- R7: A request that arrives while its line is masked stays pending. Clearing the mask bit raises `int_out` with no new edge.
- R8: A write with `wr_sel`=0 loads `wr_data` into the mask, where bit i set masks line i.
- R9: A write with `wr_sel`=1 and `wr_data`=8'h40 (bits 7:6 = 01, rest zero) ends service of the lowest-numbered in-service line. Pending lines it was blocking become eligible.
- R10: A write with `wr_sel`=1, bits 7:6 = 11, bits 5:3 zero and bits 2:0 = n ends service of line n only. Naming a line that is not in service changes nothing.
- R11: A first acknowledge pulse with no eligible line puts no line into service. The following second pulse returns vector 39.
- R12: Command writes with bits 7:6 equal to 00 or 10 leave the in-service set unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Device request lines, rising edge records a request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = mask write, 1 = command write |
| wr_data | input | 8 | Mask value or command byte |
| inta | input | 1 | Acknowledge from the processor, one rising edge per pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector on the data bus, zero while not driven |
| vec_oe | output | 1 | Data bus drive enable |

## Verification
A corrupted pending, mask or in-service bit shows up at `int_out` in the clock after the event that should have changed it. Nested scenarios are used because a stale in-service bit shows only as a request that stays silent. A wrong choice by the priority logic, or a line left in service, shows up as a wrong vector two acknowledge pulses later. The end-of-service tests therefore check `int_out` right after each command, and then the vector that follows it. A bus enable that stays high too long is caught one clock after the vector.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;

  typedef enum logic {
    ACK_IDLE  = 1'b0,
    ACK_WAIT2 = 1'b1
  } pic_ack_state_e;

  localparam logic [1:0] OP_EOI_LOWEST = 2'b01;
  localparam logic [1:0] OP_EOI_NAMED  = 2'b11;

endpackage

// File: rtl/pic_first_set.sv
`timescale 1ns/1ps
module pic_first_set #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pic_prio_pick.sv
`timescale 1ns/1ps
module pic_prio_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  serv,
  input  logic [N-1:0]  mask,
  output logic          hit,
  output logic [IW-1:0] hit_idx
);
  logic          serv_any;
  logic [IW-1:0] serv_idx;
  logic [N-1:0]  allow;
  logic [N-1:0]  cand;

  pic_first_set #(.N(N), .IW(IW)) u_serv_top (
    .vec (serv),
    .any (serv_any),
    .idx (serv_idx)
  );

  // a line may compete only if it outranks every in-service line
  for (genvar g = 0; g < N; g++) begin : g_allow
    assign allow[g] = !serv_any || (IW'(g) < serv_idx);
  end

  assign cand = pend & ~mask & allow;

  pic_first_set #(.N(N), .IW(IW)) u_cand_top (
    .vec (cand),
    .any (hit),
    .idx (hit_idx)
  );
endmodule

// File: rtl/pic_req_bank.sv
`timescale 1ns/1ps
module pic_req_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] pend_nxt
);
  logic [N-1:0] irq_prev;
  logic [N-1:0] rise;

  assign rise     = irq_in & ~irq_prev;
  assign pend_nxt = (pend_q & ~clr_vec) | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_prev <= '0;
      pend_q   <= '0;
    end else begin
      irq_prev <= irq_in;
      pend_q   <= pend_nxt;
    end
  end

  // a pending bit may only appear after its line was seen high
  AST_PEND_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & ~$past(pend_q) & ~$past(irq_in)) == '0)); // R2
endmodule

// File: rtl/pic_ack_seq.sv
`timescale 1ns/1ps
module pic_ack_seq
  import pic_pkg::*;
#(
  parameter int N        = 8,
  parameter int IW       = $clog2(N),
  parameter int DATA_W   = 8,
  parameter int VEC_BASE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inta,
  input  logic              sel_hit,
  input  logic [IW-1:0]     sel_idx,
  output logic              ack_first,
  output logic [DATA_W-1:0] vec_out,
  output logic              vec_oe
);
  localparam logic [DATA_W-1:0] BASE_V  = DATA_W'(VEC_BASE);
  localparam logic [DATA_W-1:0] SPUR_V  = DATA_W'(VEC_BASE + N - 1);

  pic_ack_state_e state_q;
  logic           inta_prev;
  logic           pulse;
  logic           ack_second;
  logic           hit_q;
  logic [IW-1:0]  idx_q;

  assign pulse      = inta && !inta_prev;
  assign ack_first  = pulse && (state_q == ACK_IDLE);
  assign ack_second = pulse && (state_q == ACK_WAIT2);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ACK_IDLE;
      inta_prev <= 1'b0;
      hit_q     <= 1'b0;
      idx_q     <= '0;
      vec_out   <= '0;
      vec_oe    <= 1'b0;
    end else begin
      inta_prev <= inta;
      vec_oe    <= ack_second;
      if (ack_second) vec_out <= hit_q ? (BASE_V + DATA_W'(idx_q)) : SPUR_V;
      else            vec_out <= '0;
      if (ack_first) begin
        state_q <= ACK_WAIT2;
        hit_q   <= sel_hit;
        idx_q   <= sel_idx;
      end else if (ack_second) begin
        state_q <= ACK_IDLE;
      end
    end
  end

  AST_OE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    vec_oe |=> !vec_oe); // R5
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !vec_oe |-> (vec_out == '0)); // R6
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    vec_oe |-> (vec_out >= BASE_V && vec_out <= SPUR_V)); // R5
endmodule

// File: rtl/pic_core.sv
`timescale 1ns/1ps
module pic_core
  import pic_pkg::*;
#(
  parameter int N_IRQ    = 8,
  parameter int DATA_W   = 8,
  parameter int VEC_BASE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              inta,
  output logic              int_out,
  output logic [DATA_W-1:0] vec_out,
  output logic              vec_oe
);
  localparam int IW = $clog2(N_IRQ);
  localparam logic [N_IRQ-1:0] ONE = N_IRQ'(1);

  logic [N_IRQ-1:0] pend_q, pend_nxt;
  logic [N_IRQ-1:0] serv_q, serv_nxt;
  logic [N_IRQ-1:0] mask_q, mask_nxt;
  logic [N_IRQ-1:0] ack_set, eoi_clr;
  logic             now_hit, nxt_hit, ack_first;
  logic [IW-1:0]    now_idx, nxt_idx;
  logic             serv_any;
  logic [IW-1:0]    serv_idx;
  logic             cmd_wr, eoi_low, eoi_named;

  pic_req_bank #(.N(N_IRQ)) u_req (
    .clk      (clk),
    .rst      (rst),
    .irq_in   (irq_in),
    .clr_vec  (ack_set),
    .pend_q   (pend_q),
    .pend_nxt (pend_nxt)
  );

  // selection for the acknowledge, from the present state
  pic_prio_pick #(.N(N_IRQ), .IW(IW)) u_pick_now (
    .pend    (pend_q),
    .serv    (serv_q),
    .mask    (mask_q),
    .hit     (now_hit),
    .hit_idx (now_idx)
  );

  // interrupt decision, from the state about to be stored
  pic_prio_pick #(.N(N_IRQ), .IW(IW)) u_pick_nxt (
    .pend    (pend_nxt),
    .serv    (serv_nxt),
    .mask    (mask_nxt),
    .hit     (nxt_hit),
    .hit_idx (nxt_idx)
  );

  pic_first_set #(.N(N_IRQ), .IW(IW)) u_serv_top (
    .vec (serv_q),
    .any (serv_any),
    .idx (serv_idx)
  );

  pic_ack_seq #(
    .N(N_IRQ), .IW(IW), .DATA_W(DATA_W), .VEC_BASE(VEC_BASE)
  ) u_ack (
    .clk       (clk),
    .rst       (rst),
    .inta      (inta),
    .sel_hit   (now_hit),
    .sel_idx   (now_idx),
    .ack_first (ack_first),
    .vec_out   (vec_out),
    .vec_oe    (vec_oe)
  );

  assign cmd_wr    = wr_en && wr_sel;
  assign eoi_low   = cmd_wr && (wr_data[7:6] == OP_EOI_LOWEST) && (wr_data[5:0] == '0);
  assign eoi_named = cmd_wr && (wr_data[7:6] == OP_EOI_NAMED)  && (wr_data[5:IW] == '0);

  always_comb begin
    eoi_clr = '0;
    if (eoi_low && serv_any) eoi_clr = ONE << serv_idx;
    else if (eoi_named)      eoi_clr = ONE << wr_data[IW-1:0];
  end

  assign ack_set  = (ack_first && now_hit) ? (ONE << now_idx) : '0;
  assign serv_nxt = (serv_q & ~eoi_clr) | ack_set;
  assign mask_nxt = (wr_en && !wr_sel) ? wr_data[N_IRQ-1:0] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      serv_q  <= '0;
      mask_q  <= '1;
      int_out <= 1'b0;
    end else begin
      serv_q  <= serv_nxt;
      mask_q  <= mask_nxt;
      int_out <= nxt_hit;
    end
  end

  logic unused_nxt_idx;
  assign unused_nxt_idx = ^nxt_idx;

  AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    int_out |-> ((pend_q & ~mask_q) != '0)); // R3
  AST_ONE_ENTRY_PER_ACK: assert property (@(posedge clk) disable iff (rst)
    $countones(serv_q & ~$past(serv_q)) <= 1); // R4
  AST_RESET_MASKED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && serv_q == '0)); // R1
endmodule

// File: tb/pic_core_tb.sv
`timescale 1ns/1ps
module pic_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       inta = 1'b0;
  logic       int_out;
  logic [7:0] vec_out;
  logic       vec_oe;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pic_core u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .inta(inta), .int_out(int_out), .vec_out(vec_out),
    .vec_oe(vec_oe)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic raise(input int line);
    irq_in[line] = 1'b1;
    step();
    irq_in[line] = 1'b0;
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  // two-pulse acknowledge; bus enable checked around the vector (R6)
  task automatic do_ack(output logic [7:0] v, output logic int_mid);
    inta = 1'b1; step(); inta = 1'b0;
    int_mid = int_out;
    check("R6 bus idle after first pulse", {7'd0, vec_oe}, 8'd0);
    step();
    inta = 1'b1; step();
    v = vec_out;
    check("R5 enable with vector", {7'd0, vec_oe}, 8'd1);
    inta = 1'b0; step();
    check("R6 enable drops", {7'd0, vec_oe}, 8'd0);
    check("R6 bus zero when idle", vec_out, 8'd0);
  endtask

  task automatic t_reset();
    check("R1 int low", {7'd0, int_out}, 8'd0);
    check("R1 enable low", {7'd0, vec_oe}, 8'd0);
    check("R1 bus zero", vec_out, 8'd0);
    raise(3);
    check("R1 masked after reset", {7'd0, int_out}, 8'd0);
  endtask

  task automatic t_mask();
    logic [7:0] v; logic im;
    write_reg(1'b0, 8'hF7);
    check("R7 held request delivered on unmask", {7'd0, int_out}, 8'd1);
    do_ack(v, im);
    check("R8 vector of unmasked line", v, 8'd35);
    write_reg(1'b1, 8'h40);
    write_reg(1'b0, 8'h00);
    check("R8 all clear, idle", {7'd0, int_out}, 8'd0);
  endtask

  task automatic t_single();
    logic [7:0] v; logic im;
    raise(6);
    check("R2 edge raises int", {7'd0, int_out}, 8'd1);
    do_ack(v, im);
    check("R4 int falls after first pulse", {7'd0, im}, 8'd0);
    check("R5 vector line 6", v, 8'd38);
    write_reg(1'b1, 8'h40);
    check("R9 idle after eoi", {7'd0, int_out}, 8'd0);
  endtask

  task automatic t_priority();
    logic [7:0] v; logic im;
    irq_in = 8'h24; step(); irq_in = '0;
    check("R2 two lines raise int", {7'd0, int_out}, 8'd1);
    do_ack(v, im);
    check("R4 lowest index wins", v, 8'd34);
    check("R3 lower line blocked", {7'd0, im}, 8'd0);
    write_reg(1'b1, 8'h40);
    check("R9 blocked line released", {7'd0, int_out}, 8'd1);
    do_ack(v, im);
    check("R4 second line served", v, 8'd37);
    write_reg(1'b1, 8'h40);
  endtask

  task automatic t_nested();
    logic [7:0] v; logic im;
    raise(4);
    do_ack(v, im);
    check("R5 vector line 4", v, 8'd36);
    raise(6);
    check("R3 lower priority held", {7'd0, int_out}, 8'd0);
    raise(1);
    check("R3 higher priority nests", {7'd0, int_out}, 8'd1);
    do_ack(v, im);
    check("R4 nested vector", v, 8'd33);
    check("R4 int falls after nest ack", {7'd0, im}, 8'd0);
    write_reg(1'b1, 8'h40);
    check("R9 clears only top line", {7'd0, int_out}, 8'd0);
    write_reg(1'b1, 8'h40);
    check("R9 second eoi releases line 6", {7'd0, int_out}, 8'd1);
    do_ack(v, im);
    check("R5 vector line 6 after nest", v, 8'd38);
    write_reg(1'b1, 8'h40);
  endtask

  task automatic t_named();
    logic [7:0] v; logic im;
    raise(2);
    do_ack(v, im);
    raise(7);
    check("R3 line 7 held by 2", {7'd0, int_out}, 8'd0);
    write_reg(1'b1, 8'hC5);
    check("R10 named eoi of idle line no effect", {7'd0, int_out}, 8'd0);
    write_reg(1'b1, 8'hC2);
    check("R10 named eoi frees line 2", {7'd0, int_out}, 8'd1);
    do_ack(v, im);
    check("R10 line 7 served", v, 8'd39);
    write_reg(1'b1, 8'h40);
  endtask

  task automatic t_ignored();
    logic [7:0] v; logic im;
    raise(3);
    do_ack(v, im);
    raise(6);
    write_reg(1'b1, 8'h00);
    check("R12 op 00 ignored", {7'd0, int_out}, 8'd0);
    write_reg(1'b1, 8'h80);
    check("R12 op 10 ignored", {7'd0, int_out}, 8'd0);
    write_reg(1'b1, 8'h40);
    check("R12 real eoi still works", {7'd0, int_out}, 8'd1);
    do_ack(v, im);
    check("R12 line 6 served", v, 8'd38);
    write_reg(1'b1, 8'h40);
  endtask

  task automatic t_spurious();
    logic [7:0] v; logic im;
    do_ack(v, im);
    check("R11 spurious vector", v, 8'd39);
    raise(7);
    check("R11 nothing put in service", {7'd0, int_out}, 8'd1);
    do_ack(v, im);
    check("R11 line 7 after spurious", v, 8'd39);
    write_reg(1'b1, 8'h40);
    check("R11 idle at end", {7'd0, int_out}, 8'd0);
  endtask

  initial begin
    repeat (4) step();
    rst = 1'b0;
    step();
    t_reset();
    t_mask();
    t_single();
    t_priority();
    t_nested();
    t_named();
    t_ignored();
    t_spurious();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule